// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of 32 general-purpose I/O pins controlled over a plain single-cycle register bus. Each pin has three data-path controls: an output value, a drive enable, and an input that is synchronised and can be read back. Each pin also has an interrupt path. Two per-pin bits select the trigger, one for level versus edge and one for polarity. A routing bit lets pin events reach the status register, and an enable bit masks status from the interrupt outputs. A status bit stays set until software clears it.

Every writable register has three access points. The base word replaces the whole value. The word at +0x4 ORs the written ones into the register, and the word at +0x8 clears the bits written as one. Software can therefore change single pins without a read-modify-write. By default all enabled pending pins are gathered onto one interrupt line. When a parameter is set, the upper half of the bank drives a second line instead.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, pin_out and pin_oe are zero and both interrupt outputs are low.
- R2: Register bases are 0x00 output, 0x10 input, 0x20 drive enable, 0x30 routing, 0x40 interrupt enable, 0x50 level select, 0x60 polarity and 0x70 status. A write at base+0x0 replaces the value, at base+0x4 sets the bits written as one, and at base+0x8 clears the bits written as one. Writes at base+0xC are ignored. A read at base, +0x4 or +0x8 returns the register in the same cycle. An address with bit 7 set, or with bits 1:0 nonzero, reads zero and writes nothing.
- R3: pin_out always equals the output register and pin_oe always equals the drive-enable register. Both change only after a write to the output or drive-enable register.
- R4: The input register shows pin_in after two flop stages, whatever the drive enable is. Writes to it are ignored.
- R5: The trigger per pin is {polarity, level}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An edge of pin_in that is held for two edges of clk sets the status bit at the third clock edge after pin_in changes.
- R6: An event sets a status bit only while that pin's routing bit is set.
- R7: A status bit stays set until a one is written to it at 0x78. Writes at 0x70 and 0x74 leave status unchanged.
- R8: While a level trigger stays active the status bit is set again every cycle. When a hardware set and a clear at 0x78 hit the same bit in the same cycle, the bit stays set.
- R9: With a single line, irq_main is high exactly when status AND interrupt enable is nonzero. Clearing an enable bit leaves the routing bit unchanged.
- R10: With the split option, irq_main covers pins 0 to 15 and irq_upper covers pins 16 to 31. Without it, irq_upper stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq_main | output | 1 | Interrupt for the bank (or its lower half when split) |
| irq_upper | output | 1 | Interrupt for pins 16 to 31 when split, else low |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a hardware re-set from a level trigger that is still active. Random stimulus almost never aligns these two. A directed sequence therefore holds a pin at its active level and then issues the clear, and it repeats the clear after the level is released. Directed steps also cover a routed-off edge, the one-cycle latency window after a pin changes, and a masked pin that still has routing. Seeded random register traffic and pin toggling then run against a cycle model in the bench, with a second instance built with the split option.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int N = 32,
  parameter int AW = 8,
  parameter bit SPLIT_IRQ = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq_main,
  output logic          irq_upper
);
  localparam int HALF = N / 2;
  localparam logic [2:0] IX_OUT = 3'd0, IX_IN = 3'd1, IX_DIR = 3'd2, IX_ROUTE = 3'd3,
                         IX_EN = 3'd4, IX_LVL = 3'd5, IX_POL = 3'd6, IX_STAT = 3'd7;

  logic [N-1:0] out_q, dir_q, route_q, en_q, lvl_q, pol_q, stat_q;
  logic [N-1:0] sync1, sync2, prev;
  logic [N-1:0] ev, clr, pend;
  logic         hit;
  logic [2:0]   sel;
  logic [1:0]   op;

  assign hit = (bus_addr[AW-1:7] == '0) && (bus_addr[1:0] == 2'b00);
  assign sel = bus_addr[6:4];
  assign op  = bus_addr[3:2];

  function automatic logic [N-1:0] upd(input logic [N-1:0] cur, input logic [2:0] idx,
                                       input logic wr, input logic [2:0] s,
                                       input logic [1:0] o, input logic [N-1:0] d);
    if (!(wr && s == idx)) return cur;
    case (o)
      2'd0:    return d;
      2'd1:    return cur | d;
      2'd2:    return cur & ~d;
      default: return cur;
    endcase
  endfunction

  // active level: pin equals polarity; edge: pin just moved to the polarity value
  assign ev  = ~(sync2 ^ pol_q) & (lvl_q | (sync2 ^ prev));
  assign clr = (bus_we && hit && sel == IX_STAT && op == 2'd2) ? bus_wdata : '0;
  assign pend = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; dir_q <= '0; route_q <= '0; en_q <= '0;
      lvl_q <= '0; pol_q <= '0; stat_q <= '0;
      sync1 <= '0; sync2 <= '0; prev <= '0;
    end else begin
      out_q   <= upd(out_q,   IX_OUT,   bus_we && hit, sel, op, bus_wdata);
      dir_q   <= upd(dir_q,   IX_DIR,   bus_we && hit, sel, op, bus_wdata);
      route_q <= upd(route_q, IX_ROUTE, bus_we && hit, sel, op, bus_wdata);
      en_q    <= upd(en_q,    IX_EN,    bus_we && hit, sel, op, bus_wdata);
      lvl_q   <= upd(lvl_q,   IX_LVL,   bus_we && hit, sel, op, bus_wdata);
      pol_q   <= upd(pol_q,   IX_POL,   bus_we && hit, sel, op, bus_wdata);
      stat_q  <= (stat_q & ~clr) | (ev & route_q);
      sync1   <= pin_in;
      sync2   <= sync1;
      prev    <= sync2;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && op != 2'd3) begin
      case (sel)
        IX_OUT:   bus_rdata = out_q;
        IX_IN:    bus_rdata = sync2;
        IX_DIR:   bus_rdata = dir_q;
        IX_ROUTE: bus_rdata = route_q;
        IX_EN:    bus_rdata = en_q;
        IX_LVL:   bus_rdata = lvl_q;
        IX_POL:   bus_rdata = pol_q;
        default:  bus_rdata = stat_q;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq_main  = |pend[HALF-1:0];
      assign irq_upper = |pend[N-1:HALF];
    end else begin : g_single
      assign irq_main  = |pend;
      assign irq_upper = 1'b0;
    end
  endgenerate
endmodule

module gpio_bank_chk #(
  parameter int N = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [N-1:0]  pin_out,
  input logic          irq_main,
  input logic          irq_upper,
  input logic [N-1:0]  stat,
  input logic [N-1:0]  route,
  input logic [N-1:0]  en
);
  localparam int HALF = N / 2;

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[AW-1:4] == '0) |=> $stable(pin_out));

  assert_route_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(route)) == '0));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(8'h78)) |=> ((stat & $past(stat)) == $past(stat)));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_main |-> ((stat & en) != '0));

  assert_upper_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_upper |-> ((stat[N-1:HALF] & en[N-1:HALF]) != '0));
endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .pin_out(pin_out), .irq_main(irq_main), .irq_upper(irq_upper),
  .stat(stat_q), .route(route_q), .en(en_q)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, pin_drv = '0, pins = '0;
  logic [31:0] rdata, rdata_s, pin_out, pin_oe, pin_out_s, pin_oe_s;
  logic irq_main, irq_upper, irq_main_s, irq_upper_s;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_out, m_dir, m_route, m_en, m_lvl, m_pol, m_stat, m_s1, m_s2, m_s3;
  bit want = 0;
  logic [31:0] want_val;
  string want_tag;

  always #5 clk = ~clk;

  gpio_bank dut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_drv), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_main(irq_main), .irq_upper(irq_upper));

  gpio_bank #(.SPLIT_IRQ(1'b1)) dut_split (.clk(clk), .rst_n(rst_n), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata_s), .pin_in(pin_drv),
    .pin_out(pin_out_s), .pin_oe(pin_oe_s), .irq_main(irq_main_s), .irq_upper(irq_upper_s));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a[7] || a[1:0] != 2'b00 || a[3:2] == 2'b11) return 32'h0;
    case (a[6:4])
      3'd0: return m_out;   3'd1: return m_s2;
      3'd2: return m_dir;   3'd3: return m_route;
      3'd4: return m_en;    3'd5: return m_lvl;
      3'd6: return m_pol;   default: return m_stat;
    endcase
  endfunction

  function automatic logic [31:0] mwr(input logic [31:0] cur, input int idx,
                                      input logic [7:0] a, input logic w, input logic [31:0] d);
    if (!w || a[7] || a[1:0] != 2'b00 || int'(a[6:4]) != idx) return cur;
    if (a[3:2] == 2'b00) return d;
    if (a[3:2] == 2'b01) return cur | d;
    if (a[3:2] == 2'b10) return cur & ~d;
    return cur;
  endfunction

  task automatic model_edge(input logic [7:0] a, input logic w, input logic [31:0] d,
                            input logic [31:0] p);
    logic [31:0] evt, clrv;
    for (int i = 0; i < 32; i++) begin
      case ({m_pol[i], m_lvl[i]})
        2'b00:   evt[i] = m_s3[i] && !m_s2[i];
        2'b01:   evt[i] = !m_s2[i];
        2'b10:   evt[i] = !m_s3[i] && m_s2[i];
        default: evt[i] = m_s2[i];
      endcase
    end
    clrv = (w && a == 8'h78) ? d : 32'h0;
    m_stat  = (m_stat & ~clrv) | (evt & m_route);
    m_out   = mwr(m_out, 0, a, w, d);
    m_dir   = mwr(m_dir, 2, a, w, d);
    m_route = mwr(m_route, 3, a, w, d);
    m_en    = mwr(m_en, 4, a, w, d);
    m_lvl   = mwr(m_lvl, 5, a, w, d);
    m_pol   = mwr(m_pol, 6, a, w, d);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = p;
  endtask

  task automatic tick(input logic [7:0] a, input logic w, input logic [31:0] d);
    logic [31:0] pd;
    @(negedge clk);
    addr = a; we = w; wdata = d; pin_drv = pins;
    #1;
    pd = m_stat & m_en;
    check("R2 read data", rdata, mread(a));
    check("R3 pin_out", pin_out, m_out);
    check("R3 pin_oe", pin_oe, m_dir);
    check("R9 irq_main", {31'b0, irq_main}, {31'b0, |pd});
    check("R10 irq_upper single", {31'b0, irq_upper}, 32'h0);
    check("R10 split low line", {31'b0, irq_main_s}, {31'b0, |pd[15:0]});
    check("R10 split high line", {31'b0, irq_upper_s}, {31'b0, |pd[31:16]});
    if (want) check(want_tag, rdata, want_val);
    want = 0;
    @(posedge clk);
    model_edge(a, w, d, pin_drv);
    #2;
  endtask

  task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
    want = 1; want_val = exp; want_tag = tag;
    tick(a, 1'b0, 32'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(8'h70, 1'b0, 32'h0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    {m_out, m_dir, m_route, m_en, m_lvl, m_pol, m_stat, m_s1, m_s2, m_s3} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int r = 0; r < 8; r++) peek(8'(r * 16), 32'h0, "R1 reset value");
    check("R1 irq after reset", {30'b0, irq_main, irq_upper_s}, 32'h0);

    tick(8'h00, 1, 32'hA5A5_0F0F);
    tick(8'h04, 1, 32'h0000_F000);
    tick(8'h08, 1, 32'hA000_000F);
    peek(8'h04, 32'h05A5_FF00, "R2 set/clear aliases");
    tick(8'h0C, 1, 32'hFFFF_FFFF);
    tick(8'h81, 1, 32'hFFFF_FFFF);
    peek(8'h00, 32'h05A5_FF00, "R2 unused offsets ignored");
    check("R3 pin_out follows register", pin_out, 32'h05A5_FF00);

    tick(8'h10, 1, 32'hFFFF_FFFF);
    pins = 32'h1234_5678;
    tick(8'h20, 1, 32'hFFFF_0000);
    peek(8'h10, 32'h0, "R4 one stage only");
    peek(8'h10, 32'h1234_5678, "R4 synchronised input");

    tick(8'h60, 1, 32'h5);
    tick(8'h50, 1, 32'hC);
    tick(8'h40, 1, 32'hF);
    tick(8'h30, 1, 32'hE);
    pins |= 32'h1;
    idle(4);
    peek(8'h70, 32'h0, "R6 edge without routing");
    tick(8'h34, 1, 32'h1);
    pins &= ~32'h1;
    idle(3);
    peek(8'h70, 32'h0, "R5 falling ignored in rising mode");
    pins |= 32'h1;
    idle(2);
    peek(8'h70, 32'h0, "R5 latency two edges");
    peek(8'h70, 32'h1, "R5 rising edge latched");
    pins |= 32'h2;
    idle(4);
    peek(8'h70, 32'h1, "R5 rise ignored in falling mode");
    pins &= ~32'h2;
    idle(4);
    peek(8'h70, 32'h3, "R5 falling edge latched");
    pins |= 32'h4;
    idle(4);
    peek(8'h70, 32'h7, "R5 high level latched");

    tick(8'h70, 1, 32'h0);
    tick(8'h74, 1, 32'hFFFF_FFFF);
    peek(8'h70, 32'h7, "R7 base and set writes ignored");
    tick(8'h78, 1, 32'h1);
    peek(8'h70, 32'h6, "R7 clear alias");

    tick(8'h78, 1, 32'h4);
    peek(8'h70, 32'h6, "R8 active level wins over clear");
    pins &= ~32'h8;
    idle(4);
    peek(8'h70, 32'hE, "R8 low level latched");
    pins |= 32'h8;
    idle(4);
    tick(8'h78, 1, 32'h8);
    peek(8'h70, 32'h6, "R8 clear after level released");

    check("R9 irq with enabled pending", {31'b0, irq_main}, 32'h1);
    tick(8'h48, 1, 32'hFFFF_FFFF);
    check("R9 irq after masking", {31'b0, irq_main}, 32'h0);
    peek(8'h30, 32'hF, "R9 masking keeps routing");

    tick(8'h64, 1, 32'h0010_0000);
    tick(8'h54, 1, 32'h0010_0000);
    tick(8'h44, 1, 32'h0010_0000);
    tick(8'h34, 1, 32'h0010_0000);
    idle(2);
    check("R10 upper line raised", {31'b0, irq_upper_s}, 32'h1);
    check("R10 lower line quiet", {31'b0, irq_main_s}, 32'h0);
    check("R10 single line raised", {31'b0, irq_main}, 32'h1);

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      a = {1'b0, 3'($urandom % 8), 2'($urandom % 4), 2'b00};
      if ($urandom % 16 == 0) a[1:0] = 2'b01;
      if ($urandom % 4 == 0) pins ^= ($urandom & $urandom & $urandom);
      tick(a, 1'($urandom % 2), $urandom);
    end

    done = 1;
    finish_run();
  end
endmodule